// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Elevation

This block sits beside a CPU core and decides which pending interrupt the core should service next. It takes a set of maskable peripheral request lines, each with its own enable bit, one external active-low maskable pin and one external active-low nonmaskable pin. The controller holds the global maskable mask (I) and the nonmaskable mask (X). At an instruction-completion strobe from the core it picks the winning source and presents its vector index with a request flag. The request is held until the core acknowledges entry. A return strobe from the core restores both masks to their values from before the matching entry.

Maskable sources follow a fixed order in which a larger vector low byte wins. An elevation register can lift any one maskable source above the rest of its group. The register is matched against each source's vector low byte, which is `VEC_LOW_BASE + 2*index`. The external maskable pin can be set to latch falling edges or to follow a low level. Stacking registers and fetching vectors stay with the core.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset irqReq is 0, iMask is 1 and xMask is 1.
- R2: A maskable source can be presented only when its enable bit is 1 and iMask is 0.
- R3: With no elevation match the highest pending index wins. Peripheral i has index i. The external maskable pin has index NUM_PERIPH and ranks above every peripheral. The nonmaskable pin has index NUM_PERIPH+1 and ranks above all maskable sources.
- R4: Writing the value VEC_LOW_BASE+2*i into the elevation register makes maskable source i win over every other pending maskable source. A value that matches no source leaves the order of R3 unchanged.
- R5: In edge mode (extEdgeMode=1) a falling edge on extPinN is latched and stays pending after the pin returns high. The latch clears when entry for index NUM_PERIPH is acknowledged. In level mode (extEdgeMode=0) the request is pending exactly while extPinN is 0.
- R6: While extEn is 0 the external maskable pin is never presented, and a falling edge in edge mode is not latched.
- R7: xMask is 1 after reset, and the xClr strobe clears it. No software input can set it again. While xMask is 1 the nonmaskable pin is not presented. While xMask is 0 it is presented whatever the value of iMask.
- R8: Acknowledging a nonmaskable entry sets both xMask and iMask. Acknowledging a maskable entry sets iMask and leaves xMask unchanged. A retStrobe restores both masks to the values they held before the most recent unreturned entry.
- R9: A request is captured only in a cycle where boundary is 1, and irqReq rises on the next clock edge. irqReq and irqVec then stay unchanged until entryAck is sampled, and irqReq falls on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periphReq | input | NUM_PERIPH | Peripheral request levels, active high |
| periphEn | input | NUM_PERIPH | Per-peripheral enable bits |
| extPinN | input | 1 | External maskable request pin, active low |
| extEn | input | 1 | Local enable of the external maskable pin |
| extEdgeMode | input | 1 | 1 = falling-edge latched, 0 = low-level sensed |
| nmiPinN | input | 1 | External nonmaskable request pin, active low |
| iSet | input | 1 | Software strobe that sets iMask |
| iClr | input | 1 | Software strobe that clears iMask |
| xClr | input | 1 | Software strobe that clears xMask |
| elevWr | input | 1 | Write strobe of the elevation register |
| elevData | input | 8 | Vector low byte to elevate |
| boundary | input | 1 | Instruction-completion strobe from the core |
| entryAck | input | 1 | Core acknowledges entry into the presented source |
| retStrobe | input | 1 | Core executes a return from interrupt |
| irqReq | output | 1 | Request to the core |
| irqVec | output | $clog2(NUM_PERIPH+2) | Index of the presented source |
| iMask | output | 1 | Global maskable mask |
| xMask | output | 1 | Nonmaskable mask |

## Verification
A boundary strobe driven in one cycle raises irqReq, with its vector, one clock edge later. The scoreboard monitor therefore compares each rising request with the front of the expected-vector queue at the falling edge just after that clock edge. The masks change on the same clock edge that samples entryAck, retStrobe or a software strobe, so the bench reads them at the following falling edge. A case in which nothing may be presented is checked one full cycle after its boundary strobe. Any request the queue does not expect is reported.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef struct packed {
    logic capture;
    logic enter;
    logic leave;
  } ctlStrobe_t;
endpackage

// File: rtl/prio_irq_ctrl_fsm.sv
module prio_irq_ctrl_fsm
  import prio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boundary,
  input  logic       entryAck,
  input  logic       retStrobe,
  input  logic       candValid,
  output ctlStrobe_t strobe,
  output logic       irqReq
);
  logic reqQ;

  always_comb begin
    strobe.capture = boundary & candValid & ~reqQ;
    strobe.enter   = entryAck & reqQ;
    strobe.leave   = retStrobe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reqQ <= 1'b0;
    else if (strobe.capture) reqQ <= 1'b1;
    else if (strobe.enter) reqQ <= 1'b0;
  end

  assign irqReq = reqQ;

  AST_REQ_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reqQ) |-> $past(boundary)); // R9
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (reqQ && !entryAck) |=> reqQ); // R9
  AST_REQ_DROPS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (reqQ && entryAck) |=> !reqQ); // R9
endmodule

// File: rtl/prio_irq_datapath.sv
module prio_irq_datapath
  import prio_irq_pkg::*;
#(
  parameter int NUM_PERIPH   = 6,
  parameter int VEC_LOW_BASE = 'hC0,
  parameter int SAVE_DEPTH   = 4,
  parameter int ELEV_RESET   = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PERIPH-1:0] periphReq,
  input  logic [NUM_PERIPH-1:0] periphEn,
  input  logic                  extPinN,
  input  logic                  extEn,
  input  logic                  extEdgeMode,
  input  logic                  nmiPinN,
  input  logic                  iSet,
  input  logic                  iClr,
  input  logic                  xClr,
  input  logic                  elevWr,
  input  logic [7:0]            elevData,
  input  ctlStrobe_t            strobe,
  output logic                  candValid,
  output logic [$clog2(NUM_PERIPH+2)-1:0] vecOut,
  output logic                  iMask,
  output logic                  xMask
);
  localparam int NUM_MASK = NUM_PERIPH + 1;
  localparam int EXT_IDX  = NUM_PERIPH;
  localparam int NMI_IDX  = NUM_MASK;
  localparam int VW       = $clog2(NMI_IDX + 1);
  localparam int SPW      = $clog2(SAVE_DEPTH + 1);
  localparam int SIW      = (SAVE_DEPTH > 1) ? $clog2(SAVE_DEPTH) : 1;

  logic [NUM_MASK-1:0] maskPend;
  logic                extPend, nmiPend;
  logic                edgeLatchQ, pinPrevQ;
  logic [7:0]          elevQ;
  logic                elevPend;
  logic [VW-1:0]       elevIdx, topIdx, candIdx, vecQ;
  logic                iMaskQ, xMaskQ;
  logic [1:0]          saveStk [SAVE_DEPTH];
  logic [SPW-1:0]      spQ;
  logic [SIW-1:0]      pushIdx, popIdx;
  logic                enterExt, enterNmi;

  // Pending vector, external pin sensed by the selected mode
  always_comb begin
    extPend  = extEn & (extEdgeMode ? edgeLatchQ : ~extPinN);
    maskPend = {extPend, periphReq & periphEn};
    nmiPend  = ~nmiPinN & ~xMaskQ;
  end

  // Fixed order plus elevation match, one comparator per maskable source
  always_comb begin
    elevPend = 1'b0;
    elevIdx  = '0;
    topIdx   = '0;
    for (int i = 0; i < NUM_MASK; i++) begin
      if (maskPend[i]) topIdx = VW'(i);
      if (maskPend[i] && (elevQ == 8'(VEC_LOW_BASE + 2 * i))) begin
        elevPend = 1'b1;
        elevIdx  = VW'(i);
      end
    end
  end

  always_comb begin
    candValid = 1'b0;
    candIdx   = '0;
    if (nmiPend) begin
      candValid = 1'b1;
      candIdx   = VW'(NMI_IDX);
    end else if (!iMaskQ && (|maskPend)) begin
      candValid = 1'b1;
      candIdx   = elevPend ? elevIdx : topIdx;
    end
  end

  assign enterExt = strobe.enter && (vecQ == VW'(EXT_IDX));
  assign enterNmi = strobe.enter && (vecQ == VW'(NMI_IDX));
  assign pushIdx  = spQ[SIW-1:0];
  assign popIdx   = SIW'(spQ - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vecQ       <= '0;
      elevQ      <= 8'(ELEV_RESET);
      pinPrevQ   <= 1'b1;
      edgeLatchQ <= 1'b0;
    end else begin
      if (strobe.capture) vecQ <= candIdx;
      if (elevWr) elevQ <= elevData;
      pinPrevQ <= extPinN;
      if (extEn && extEdgeMode && pinPrevQ && !extPinN) edgeLatchQ <= 1'b1;
      else if (enterExt) edgeLatchQ <= 1'b0;
    end
  end

  // Mask registers with a save stack for nested entries
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iMaskQ <= 1'b1;
      xMaskQ <= 1'b1;
      spQ    <= '0;
      for (int d = 0; d < SAVE_DEPTH; d++) saveStk[d] <= 2'b11;
    end else if (strobe.enter) begin
      if (spQ < SPW'(SAVE_DEPTH)) begin
        saveStk[pushIdx] <= {xMaskQ, iMaskQ};
        spQ <= spQ + 1'b1;
      end
      iMaskQ <= 1'b1;
      if (enterNmi) xMaskQ <= 1'b1;
    end else if (strobe.leave && (spQ != '0)) begin
      {xMaskQ, iMaskQ} <= saveStk[popIdx];
      spQ <= spQ - 1'b1;
    end else begin
      if (iSet) iMaskQ <= 1'b1;
      else if (iClr) iMaskQ <= 1'b0;
      if (xClr) xMaskQ <= 1'b0;
    end
  end

  assign vecOut = vecQ;
  assign iMask  = iMaskQ;
  assign xMask  = xMaskQ;

  AST_X_SET_ONLY_BY_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xMaskQ) |-> ($past(enterNmi) || $past(strobe.leave))); // R7
  AST_NMI_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    enterNmi |=> (xMaskQ && iMaskQ)); // R8
  AST_MASK_ENTRY_KEEPS_X: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.enter && !enterNmi) |=> (iMaskQ && $stable(xMaskQ))); // R8
  AST_MASKABLE_NEEDS_I_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.capture && candIdx != VW'(NMI_IDX)) |-> !iMaskQ); // R2
  AST_EDGE_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (edgeLatchQ && !enterExt) |=> edgeLatchQ); // R5
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_PERIPH   = 6,
  parameter int VEC_LOW_BASE = 'hC0,
  parameter int SAVE_DEPTH   = 4,
  parameter int ELEV_RESET   = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PERIPH-1:0] periphReq,
  input  logic [NUM_PERIPH-1:0] periphEn,
  input  logic                  extPinN,
  input  logic                  extEn,
  input  logic                  extEdgeMode,
  input  logic                  nmiPinN,
  input  logic                  iSet,
  input  logic                  iClr,
  input  logic                  xClr,
  input  logic                  elevWr,
  input  logic [7:0]            elevData,
  input  logic                  boundary,
  input  logic                  entryAck,
  input  logic                  retStrobe,
  output logic                  irqReq,
  output logic [$clog2(NUM_PERIPH+2)-1:0] irqVec,
  output logic                  iMask,
  output logic                  xMask
);
  ctlStrobe_t strobe;
  logic       candValid;

  prio_irq_ctrl_fsm u_ctl (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .entryAck(entryAck),
    .retStrobe(retStrobe), .candValid(candValid), .strobe(strobe), .irqReq(irqReq)
  );

  prio_irq_datapath #(
    .NUM_PERIPH(NUM_PERIPH), .VEC_LOW_BASE(VEC_LOW_BASE),
    .SAVE_DEPTH(SAVE_DEPTH), .ELEV_RESET(ELEV_RESET)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .periphReq(periphReq), .periphEn(periphEn),
    .extPinN(extPinN), .extEn(extEn), .extEdgeMode(extEdgeMode), .nmiPinN(nmiPinN),
    .iSet(iSet), .iClr(iClr), .xClr(xClr), .elevWr(elevWr), .elevData(elevData),
    .strobe(strobe), .candValid(candValid), .vecOut(irqVec), .iMask(iMask), .xMask(xMask)
  );
endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  localparam int NP = 6;
  localparam int BASE = 'hC0;
  localparam int EXTV = NP;
  localparam int NMIV = NP + 1;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0] periphReq = '0, periphEn = '0;
  logic extPinN = 1, extEn = 0, extEdgeMode = 0, nmiPinN = 1;
  logic iSet = 0, iClr = 0, xClr = 0, elevWr = 0;
  logic [7:0] elevData = '0;
  logic boundary = 0, entryAck = 0, retStrobe = 0;
  logic irqReq, iMask, xMask;
  logic [$clog2(NP+2)-1:0] irqVec;

  int checks = 0, errors = 0;
  bit finished = 0;
  int expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  prio_irq_ctrl #(.NUM_PERIPH(NP), .VEC_LOW_BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .periphReq(periphReq), .periphEn(periphEn),
    .extPinN(extPinN), .extEn(extEn), .extEdgeMode(extEdgeMode), .nmiPinN(nmiPinN),
    .iSet(iSet), .iClr(iClr), .xClr(xClr), .elevWr(elevWr), .elevData(elevData),
    .boundary(boundary), .entryAck(entryAck), .retStrobe(retStrobe),
    .irqReq(irqReq), .irqVec(irqVec), .iMask(iMask), .xMask(xMask)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: compare each newly raised request with the scoreboard front
  initial begin
    bit seen = 0;
    forever begin
      @(negedge clk);
      if (rst_n && irqReq && !seen) begin
        seen = 1;
        if (expQ.size() == 0) check("R9 unexpected request vec", int'(irqVec), -1);
        else check(tagQ.pop_front(), int'(irqVec), expQ.pop_front());
      end
      if (!irqReq) seen = 0;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseBoundary();
    boundary = 1; @(negedge clk); boundary = 0;
  endtask

  task automatic expectNone(string tag);
    pulseBoundary(); step(1);
    check(tag, int'(irqReq), 0);
  endtask

  task automatic enterVec(int vec, string tag);
    expQ.push_back(vec); tagQ.push_back(tag);
    pulseBoundary(); step(1);
    entryAck = 1; @(negedge clk); entryAck = 0;
  endtask

  task automatic doReturn();
    retStrobe = 1; @(negedge clk); retStrobe = 0;
  endtask

  task automatic writeElev(int v);
    elevData = 8'(v); elevWr = 1; @(negedge clk); elevWr = 0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    check("R1 irqReq", int'(irqReq), 0);
    check("R1 iMask", int'(iMask), 1);
    check("R1 xMask", int'(xMask), 1);

    // R2: I set blocks an enabled source
    periphReq[0] = 1; periphEn[0] = 1;
    expectNone("R2 blocked by iMask");
    iClr = 1; @(negedge clk); iClr = 0;
    check("R2 iMask cleared", int'(iMask), 0);
    periphEn[0] = 0;
    expectNone("R2 disabled source ignored");
    periphEn[0] = 1;
    enterVec(0, "R2 enabled source vec");
    check("R8 maskable entry sets I", int'(iMask), 1);
    check("R8 maskable entry keeps X", int'(xMask), 1);
    periphReq[0] = 0;
    doReturn();
    check("R8 return restores I", int'(iMask), 0);

    // R3: fixed priority
    periphEn = '1;
    periphReq[1] = 1; periphReq[3] = 1; periphReq[5] = 1;
    enterVec(5, "R3 highest index wins");
    periphReq[5] = 0; doReturn();
    enterVec(3, "R3 next highest");
    doReturn();
    periphReq = '0;

    // R9: only at boundary, held until ack
    periphReq[2] = 1;
    step(4);
    check("R9 no request without boundary", int'(irqReq), 0);
    expQ.push_back(2); tagQ.push_back("R9 vec at boundary");
    pulseBoundary();
    step(3);
    check("R9 request held", int'(irqReq), 1);
    check("R9 vector held", int'(irqVec), 2);
    entryAck = 1; @(negedge clk); entryAck = 0;
    check("R9 request drops on ack", int'(irqReq), 0);
    periphReq = '0; doReturn();

    // R4: elevation
    writeElev(BASE + 2 * 1);
    periphReq[1] = 1; periphReq[5] = 1;
    enterVec(1, "R4 elevated source wins");
    doReturn();
    writeElev('h33);
    enterVec(5, "R4 unmatched value keeps order");
    doReturn();

    // R5 level mode and R3 external above peripherals
    extEn = 1; extEdgeMode = 0; extPinN = 0;
    enterVec(EXTV, "R3 external pin above peripherals");
    periphReq = '0; extPinN = 1;
    doReturn();
    expectNone("R5 level follows pin");

    // R5 edge mode
    extEdgeMode = 1;
    extPinN = 0; step(1); extPinN = 1; step(2);
    enterVec(EXTV, "R5 edge latched");
    doReturn();
    expectNone("R5 latch cleared by ack");

    // R6 local enable
    extEn = 0;
    extPinN = 0; step(1); extPinN = 1; step(1);
    expectNone("R6 disabled pin ignored");
    extEn = 1;
    expectNone("R6 edge not latched while disabled");

    // R7 / R8 nonmaskable
    nmiPinN = 0;
    expectNone("R7 X mask blocks nonmaskable");
    xClr = 1; @(negedge clk); xClr = 0;
    check("R7 X cleared by software", int'(xMask), 0);
    iSet = 1; @(negedge clk); iSet = 0;
    check("R7 iMask set", int'(iMask), 1);
    enterVec(NMIV, "R7 nonmaskable ignores I");
    check("R8 nonmaskable entry sets X", int'(xMask), 1);
    check("R8 nonmaskable entry sets I", int'(iMask), 1);
    nmiPinN = 1;
    doReturn();
    check("R8 return restores X", int'(xMask), 0);
    check("R8 return restores I", int'(iMask), 1);
    xClr = 1; @(negedge clk); xClr = 0;
    check("R7 X stays clear", int'(xMask), 0);

    step(2);
    check("R9 scoreboard drained", expQ.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule